// File: doc/BRIEF.md
# Coil Drive Phase Sequencer

This block steps a solenoid driver through three phases: idle, a high-current pull-in phase and a reduced-current hold phase. It tells a downstream PWM chopper when it may switch, and gives it the current reference code to regulate against. A large reference is used while the armature pulls in. After a programmable number of cycles the reference drops to a smaller hold level, which keeps dissipation down for as long as the coil stays energised.

The two reference codes come from small setting codes. A setting below a minimum selects a fixed default. Any other setting gives a level inversely proportional to the code, and the hold level is one sixth of the pull-in level for the same code. Chopping starts only after a start-up delay following activation.

An undervoltage flag and a thermal latch with hysteresis both force the idle outputs. A status pulldown enable shows when the driver is enabled and free of faults. When a fault clears while the enable is still high, the sequence starts over from the pull-in phase.

Top module: `coil_seq`

## Requirements
- R1: During and after reset, `run` and `stat_pd` are 0 and the block is idle, so `ref_code` shows the pull-in level.
- R2: From idle, a cycle with `en`=1 and no fault moves the block to the pull-in phase at the next clock edge. The pull-in phase lasts `keep_cnt` cycles, with a minimum of one, and then the hold phase begins.
- R3: `run` stays 0 for the first DELAY_CYC cycles of the pull-in phase and rises on the cycle after that.
- R4: The hold phase lasts as long as `en` stays high with no fault. In that phase `ref_code` is the hold level.
- R5: With `en`=0, `run` is 0 in the same cycle and the block is idle from the next edge. The next time `en` is high, a fresh pull-in phase starts.
- R6: A setting code below SET_MIN (32), including 0, selects the default level: 300 for pull-in and 50 for hold.
- R7: Any other setting code N gives a pull-in level of floor(57600/N) and a hold level of floor(9600/N), both saturated to 1023. Codes are in 1 mV steps.
- R8: The pull-in setting and the hold setting are decoded independently of each other.
- R9: `uv_flag`=1 drives `run` and `stat_pd` to 0 in the same cycle and makes the block idle from the next edge.
- R10: `temp_c` is a signed 9-bit code in degrees C. A code above 160 sets a thermal latch at the next edge. The latch clears only on a code below 140. While the latch is set, `run` and `stat_pd` are 0.
- R11: When a fault clears while `en` is high, the block starts a new pull-in phase with a fresh keep count and a fresh start-up delay.
- R12: `stat_pd` is 1 exactly when `en` is high, `uv_flag` is low and the thermal latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Drive request |
| keep_cnt | input | KEEP_W | Length of the pull-in phase in cycles |
| peak_set | input | SET_W | Pull-in setting code |
| hold_set | input | SET_W | Hold setting code |
| uv_flag | input | 1 | Supply undervoltage indication |
| temp_c | input | TEMP_W | Signed junction temperature code |
| run | output | 1 | Chopper switching permission |
| ref_code | output | REF_W | Current reference for the chopper |
| stat_pd | output | 1 | Status pulldown enable |

## Verification
The checks that hold on every cycle cover these cases: enable low or undervoltage keeps `run` and `stat_pd` low in that same cycle; a temperature code above the trip point clears both on the next cycle; the thermal latch stays set while the code remains at or above the release point; and `run` never rises before the status pulldown has been active for longer than the start-up delay. Other behaviour can only be shown by the bench's scenarios. That includes the exact pull-in length and the reference values, with their saturation, defaults and independence. It also includes the one-cycle lag after a thermal release and the restart of the full sequence after each fault.

// File: rtl/coil_seq.sv
module coil_seq #(
  parameter int REF_W     = 10,
  parameter int SET_W     = 8,
  parameter int KEEP_W    = 16,
  parameter int TEMP_W    = 9,
  parameter int DELAY_CYC = 12500,
  parameter int SET_MIN   = 32,
  parameter int PEAK_DEF  = 300,
  parameter int HOLD_DEF  = 50,
  parameter int PEAK_NUM  = 57600,
  parameter int HOLD_DIV  = 6,
  parameter int TRIP      = 160,
  parameter int CLEAR     = 140
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [KEEP_W-1:0]        keep_cnt,
  input  logic [SET_W-1:0]         peak_set,
  input  logic [SET_W-1:0]         hold_set,
  input  logic                     uv_flag,
  input  logic signed [TEMP_W-1:0] temp_c,
  output logic                     run,
  output logic [REF_W-1:0]         ref_code,
  output logic                     stat_pd
);
  localparam int HOLD_NUM = PEAK_NUM / HOLD_DIV;
  localparam int REF_MAX  = (1 << REF_W) - 1;
  localparam int DLY_W    = $clog2(DELAY_CYC + 1);
  localparam logic [DLY_W-1:0] DLY_END = DLY_W'(DELAY_CYC);
  localparam logic signed [TEMP_W-1:0] TRIP_C  = TEMP_W'(TRIP);
  localparam logic signed [TEMP_W-1:0] CLEAR_C = TEMP_W'(CLEAR);

  typedef enum logic [1:0] {PH_OFF, PH_PEAK, PH_HOLD} phase_t;

  function automatic logic [REF_W-1:0] pick(input logic [SET_W-1:0] n, input int num, input int dflt);
    int q;
    if (int'(n) < SET_MIN) return REF_W'(dflt);
    q = num / int'(n);
    return (q > REF_MAX) ? REF_W'(REF_MAX) : REF_W'(q);
  endfunction

  phase_t            ph;
  logic [KEEP_W-1:0] kt;
  logic [DLY_W-1:0]  dly;
  logic              ot_q;
  logic              ok;
  logic              keep_done;
  logic [REF_W-1:0]  peak_ref, hold_ref;

  assign ok        = en & ~uv_flag & ~ot_q;
  assign keep_done = ({1'b0, kt} + (KEEP_W+1)'(1)) >= {1'b0, keep_cnt};
  assign peak_ref  = pick(peak_set, PEAK_NUM, PEAK_DEF);
  assign hold_ref  = pick(hold_set, HOLD_NUM, HOLD_DEF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ot_q <= 1'b0;
    else if (temp_c > TRIP_C)  ot_q <= 1'b1;
    else if (temp_c < CLEAR_C) ot_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_OFF;
      kt  <= '0;
      dly <= '0;
    end else if (!ok) begin
      ph  <= PH_OFF;
      kt  <= '0;
      dly <= '0;
    end else begin
      if (ph != PH_OFF && dly != DLY_END) dly <= dly + DLY_W'(1);
      case (ph)
        PH_OFF:  ph <= PH_PEAK;
        PH_PEAK: begin
          if (keep_done) begin
            ph <= PH_HOLD;
            kt <= '0;
          end else begin
            kt <= kt + KEEP_W'(1);
          end
        end
        PH_HOLD: ph <= PH_HOLD;
        default: ph <= PH_OFF;
      endcase
    end
  end

  assign run      = (ph != PH_OFF) & (dly == DLY_END) & ok;
  assign stat_pd  = ok;
  assign ref_code = (ph == PH_HOLD) ? hold_ref : peak_ref;
endmodule

// File: rtl/coil_seq_sva.sv
module coil_seq_sva #(
  parameter int TEMP_W    = 9,
  parameter int DELAY_CYC = 12500,
  parameter int TRIP      = 160,
  parameter int CLEAR     = 140
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     en,
  input logic                     uv_flag,
  input logic signed [TEMP_W-1:0] temp_c,
  input logic                     run,
  input logic                     stat_pd
);
  localparam int CW = $clog2(DELAY_CYC + 2);
  localparam logic [CW-1:0] CMAX = CW'(DELAY_CYC + 1);
  localparam logic signed [TEMP_W-1:0] TRIP_C  = TEMP_W'(TRIP);
  localparam logic signed [TEMP_W-1:0] CLEAR_C = TEMP_W'(CLEAR);

  logic [CW-1:0] pd_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pd_cnt <= '0;
    else if (!stat_pd)   pd_cnt <= '0;
    else if (pd_cnt != CMAX) pd_cnt <= pd_cnt + CW'(1);
  end

  assert_en_low_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!run && !stat_pd));

  assert_uv_same_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |-> (!run && !stat_pd));

  assert_hot_trip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_c > TRIP_C) |=> (!run && !stat_pd));

  assert_latch_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !uv_flag && !stat_pd && temp_c >= CLEAR_C) ##1 (en && !uv_flag) |-> !stat_pd);

  assert_startup_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (int'(pd_cnt) > DELAY_CYC));
endmodule

bind coil_seq coil_seq_sva #(
  .TEMP_W(TEMP_W), .DELAY_CYC(DELAY_CYC), .TRIP(TRIP), .CLEAR(CLEAR)
) u_sva (
  .clk(clk), .rst_n(rst_n), .en(en), .uv_flag(uv_flag), .temp_c(temp_c),
  .run(run), .stat_pd(stat_pd)
);

// File: tb/coil_seq_bench.sv
module coil_seq_bench;
  localparam int DLY = 8;

  typedef struct {
    logic  run;
    int    refv;
    logic  pd;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [15:0]       keep_cnt = '0;
  logic [7:0]        peak_set = '0;
  logic [7:0]        hold_set = '0;
  logic              uv_flag = 1'b0;
  logic signed [8:0] temp_c = 9'sd25;
  logic              run;
  logic [9:0]        ref_code;
  logic              stat_pd;

  int checks = 0;
  int fails = 0;
  exp_t q[$];
  int cur_ps = 0, cur_hs = 0, cur_kp = 0;
  bit done = 0;

  always #2 clk = ~clk;

  coil_seq #(.DELAY_CYC(DLY)) u_coil_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .keep_cnt(keep_cnt),
    .peak_set(peak_set), .hold_set(hold_set), .uv_flag(uv_flag),
    .temp_c(temp_c), .run(run), .ref_code(ref_code), .stat_pd(stat_pd)
  );

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (run !== e.run || int'(ref_code) != e.refv || stat_pd !== e.pd) begin
        fails++;
        $display("FAIL %s: run/ref/pd actual %b/%0d/%b expected %b/%0d/%b at %0t",
                 e.tag, run, ref_code, stat_pd, e.run, e.refv, e.pd, $time);
      end
    end
  end

  task automatic cfg(input int ps, input int hs, input int kp);
    cur_ps = ps; cur_hs = hs; cur_kp = kp;
  endtask

  task automatic step(input logic e, input logic u, input int t,
                      input logic er, input int eref, input logic epd, input string tag);
    exp_t x;
    @(negedge clk);
    en = e; uv_flag = u; temp_c = 9'(t);
    peak_set = 8'(cur_ps); hold_set = 8'(cur_hs); keep_cnt = 16'(cur_kp);
    x.run = er; x.refv = eref; x.pd = epd; x.tag = tag;
    q.push_back(x);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    cfg(0, 0, 20);
    step(0, 0, 25, 0, 300, 0, "R1 reset");
    step(0, 0, 25, 0, 300, 0, "R1 reset");
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 25, 0, 300, 0, "R1 idle");
    step(0, 0, 25, 0, 300, 0, "R1 idle");

    // default references, delay, keep length, hold
    for (int i = 1; i <= 40; i++)
      step(1, 0, 25, i >= 1 + DLY, (i >= 21) ? 50 : 300, 1, "R2 R3 R4 R6 R12");
    for (int i = 0; i < 3; i++) step(0, 0, 25, 0, 300, 0, "R5 R12");

    // scaled settings, fresh sequence after re-enable
    cfg(64, 64, 5);
    step(0, 0, 25, 0, 900, 0, "R7");
    for (int i = 1; i <= 14; i++)
      step(1, 0, 25, i >= 1 + DLY, (i >= 6) ? 150 : 900, 1, "R5 R7");
    step(0, 0, 25, 0, 900, 0, "R5");

    // saturation and independent default
    cfg(40, 31, 2);
    step(0, 0, 25, 0, 1023, 0, "R7 saturation");
    for (int i = 1; i <= 4; i++)
      step(1, 0, 25, 0, (i >= 3) ? 50 : 1023, 1, "R7 R8");
    step(0, 0, 25, 0, 1023, 0, "R8");

    // keep count zero, truncating division
    cfg(255, 200, 0);
    for (int i = 1; i <= 3; i++)
      step(1, 0, 25, 0, (i >= 2) ? 48 : 225, 1, "R2 R7");
    step(0, 0, 25, 0, 225, 0, "R5");

    // threshold boundary on each setting
    cfg(31, 33, 1);
    for (int i = 1; i <= 2; i++)
      step(1, 0, 25, 0, (i >= 2) ? 290 : 300, 1, "R6 R8");
    step(0, 0, 25, 0, 300, 0, "R5");

    // undervoltage and restart
    cfg(0, 0, 20);
    for (int i = 1; i <= 12; i++)
      step(1, 0, 25, i >= 1 + DLY, 300, 1, "R3");
    step(1, 1, 25, 0, 300, 0, "R9");
    step(1, 1, 25, 0, 300, 0, "R9");
    for (int j = 1; j <= 24; j++)
      step(1, 0, 25, j >= 1 + DLY, (j >= 21) ? 50 : 300, 1, "R11");

    // thermal latch with hysteresis
    step(1, 0, 160, 1, 50, 1, "R10 at trip");
    step(1, 0, 160, 1, 50, 1, "R10 at trip");
    step(1, 0, 161, 0, 50, 0, "R10 tripped");
    step(1, 0, 150, 0, 300, 0, "R10 latched");
    step(1, 0, 140, 0, 300, 0, "R10 at release");
    step(1, 0, 140, 0, 300, 0, "R10 at release");
    step(1, 0, 139, 0, 300, 1, "R10 R12 released");
    for (int j = 2; j <= 25; j++)
      step(1, 0, 25, j >= 2 + DLY, (j >= 22) ? 50 : 300, 1, "R10 R11");
    step(0, 0, 25, 0, 300, 0, "R5");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule